// File: doc/BRIEF.md
# Serial Audio Word Clock Generator

This block produces the timing for a stereo serial audio port: a bit clock, a left/right word strobe and a sample interrupt. As clock master it divides the system clock by a programmable 8-bit value. One half-period of the bit clock lasts (divider + 1) system cycles, and the word strobe changes level after every 32 bit-clock half-periods. A full stereo frame therefore takes 32 × 2 × (divider + 1) system cycles. As slave it drives no clock of its own. Its sample timing then comes from an external word strobe, which passes through a two-flop synchroniser.

Software sees three registers. The divider register resets to 8, and writing it restarts the frame from the beginning. The mode register holds the master select, the strobe enable and three interrupt selects: rising strobe edge, falling strobe edge, and start of every word. A two-bit status word gives the current strobe level and a left-channel flag. The interrupt is a single-cycle pulse, meant for the block that loads the next sample pair. Shifting the audio data itself is left to the neighbouring serialiser.

Top module: `audio_wclk_gen`

## Requirements
- R1: After reset, `div_value` is 8, `mode_value` is 0, `bit_clk`, `word_strobe` and `sample_irq` are low, and `status` is 2'b10.
- R2: A write with `reg_sel`=0 loads the divider from `reg_wdata`. A write with `reg_sel`=1 loads the mode register, which keeps only bits 0, 2, 3, 4 and 5 and reads all other bits as zero. Writing 8'hFF therefore reads back as 8'h3D.
- R3: In master mode (mode bit 0 set), `bit_clk` changes level every (divider + 1) system clock cycles.
- R4: In master mode, the strobe phase changes level after every 32 bit-clock half-periods, that is every 32 × (divider + 1) cycles. A frame is therefore 64 × (divider + 1) cycles.
- R5: A divider write restarts the timing. Right after the write edge, `bit_clk` and `word_strobe` are low. The first `bit_clk` change comes (new divider + 1) cycles after that edge, and the first strobe change comes 32 × (new divider + 1) cycles after it.
- R6: With mode bit 2 (strobe enable) clear, `word_strobe` stays low while `bit_clk` keeps toggling and `status[1]` keeps following the phase.
- R7: `status[0]` is the strobe level (`word_strobe` in master mode, the synchronised external strobe in slave mode). `status[1]` is 1 while the phase is low, marking the left channel.
- R8: Mode bit 3 gives a rising-edge interrupt and mode bit 4 a falling-edge interrupt. In master mode the pulse is high for exactly one cycle, one cycle after the strobe phase changes. With both bits set, both edges pulse.
- R9: Mode bit 5 pulses the interrupt at the start of every word, which is every strobe edge. With bits 3, 4 and 5 all clear, no interrupt is raised.
- R10: In slave mode (mode bit 0 clear), `bit_clk` and `word_strobe` stay low. `status[0]` follows `ext_ws` on the second rising clock edge after it changes, and an enabled interrupt pulses on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the divider register, 1 selects the mode register |
| reg_wdata | input | 8 | Write data |
| ext_ws | input | 1 | External word strobe, used in slave mode |
| div_value | output | 8 | Current divider register |
| mode_value | output | 8 | Current mode register |
| status | output | 2 | {left channel, strobe level} |
| bit_clk | output | 1 | Generated bit clock |
| word_strobe | output | 1 | Generated left/right word strobe |
| sample_irq | output | 1 | One-cycle sample interrupt pulse |

## Verification
The master timing runs with the divider at 0, at 3 and at 10. The zero setting shows that the bit clock can toggle every cycle. The non-zero settings separate a correct (divider + 1) scale from an off-by-one, and confirm the fixed 32:1 ratio between strobe and bit clock. The interrupt selects are tried alone, together and all clear on the same restarted timeline. The pulse counts tell rising edges from falling edges, because a window of seven strobe edges holds four rising and three falling ones. A restart in the middle of a frame, a run with the strobe disabled and a slave sequence driven cycle by cycle on `ext_ws` check the restart, the output gating and the synchroniser latency.

// File: rtl/awg_pkg.sv
package awg_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic {
    SEL_DIV  = 1'b0,
    SEL_MODE = 1'b1
  } awg_sel_e;

  localparam int MB_MASTER = 0;
  localparam int MB_WSEN   = 2;
  localparam int MB_RISE   = 3;
  localparam int MB_FALL   = 4;
  localparam int MB_EVERY  = 5;

  localparam logic [DATA_W-1:0] MODE_KEEP = 8'h3D;
endpackage

// File: rtl/awg_prescale.sv
module awg_prescale #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             bclk
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_d;

  always_comb begin
    tick   = !clear && (cnt_q == div);
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (clear) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      bclk_d = ~bclk_q;
    end else begin
      cnt_d  = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk = bclk_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div);

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0 && !bclk_q));
endmodule

// File: rtl/awg_frame.sv
module awg_frame #(
  parameter int unsigned HALVES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic phase
);
  localparam int unsigned HC_W = $clog2(HALVES);

  logic [HC_W-1:0] half_q, half_d;
  logic            phase_q, phase_d;
  logic            last;

  always_comb begin
    last    = (half_q == HC_W'(HALVES - 1));
    half_d  = half_q;
    phase_d = phase_q;
    if (clear) begin
      half_d  = '0;
      phase_d = 1'b0;
    end else if (tick) begin
      half_d  = last ? '0 : half_q + HC_W'(1);
      phase_d = last ? ~phase_q : phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      half_q  <= half_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

  assert_half_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(half_q));

  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(tick && last)) |=> $stable(phase_q));
endmodule

// File: rtl/awg_sync.sv
module awg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] stg_q, stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign sync_out = stg_q[STAGES-1];

  assert_sync_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (sync_out == $past(stg_q[STAGES-2])));
endmodule

// File: rtl/audio_wclk_gen.sv
module audio_wclk_gen
  import awg_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned HALVES      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_RST     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              ext_ws,
  output logic [DIV_W-1:0]  div_value,
  output logic [DATA_W-1:0] mode_value,
  output logic [1:0]        status,
  output logic              bit_clk,
  output logic              word_strobe,
  output logic              sample_irq
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_core;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  // Registers.
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DATA_W-1:0] mode_q, mode_d;
  logic              div_wr, mode_wr;

  always_comb begin
    div_wr  = reg_wr && (reg_sel == SEL_DIV);
    mode_wr = reg_wr && (reg_sel == SEL_MODE);
    div_d   = div_wr  ? reg_wdata[DIV_W-1:0] : div_q;
    mode_d  = mode_wr ? (reg_wdata & MODE_KEEP) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      div_q  <= DIV_W'(DIV_RST);
      mode_q <= '0;
    end else begin
      div_q  <= div_d;
      mode_q <= mode_d;
    end
  end

  // Timing chain.
  logic master, clear, tick, bclk, frame_phase, ext_sync;

  assign master = mode_q[MB_MASTER];
  assign clear  = div_wr || !master;

  awg_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk   (clk),
    .rst_n (rst_core),
    .clear (clear),
    .div   (div_q),
    .tick  (tick),
    .bclk  (bclk)
  );

  awg_frame #(.HALVES(HALVES)) u_frame (
    .clk   (clk),
    .rst_n (rst_core),
    .clear (clear),
    .tick  (tick),
    .phase (frame_phase)
  );

  awg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core),
    .async_in (ext_ws),
    .sync_out (ext_sync)
  );

  // Edge detection and interrupt.
  logic phase, phase_q, rise, fall, irq_d, irq_q;

  always_comb begin
    phase = master ? frame_phase : ext_sync;
    rise  = phase && !phase_q;
    fall  = !phase && phase_q;
    irq_d = (mode_q[MB_RISE]  && rise) ||
            (mode_q[MB_FALL]  && fall) ||
            (mode_q[MB_EVERY] && (rise || fall));
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      phase_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      phase_q <= phase;
      irq_q   <= irq_d;
    end
  end

  assign bit_clk     = master && bclk;
  assign word_strobe = master && mode_q[MB_WSEN] && frame_phase;
  assign status      = {~phase, master ? word_strobe : ext_sync};
  assign sample_irq  = irq_q;
  assign div_value   = div_q;
  assign mode_value  = mode_q;

  assert_irq_edge_R8: assert property (@(posedge clk) disable iff (!rst_core)
    sample_irq |-> (phase_q != $past(phase_q)));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_core)
    sample_irq |-> ($past(mode_q[MB_RISE]) || $past(mode_q[MB_FALL]) || $past(mode_q[MB_EVERY])));
endmodule

// File: tb/audio_wclk_gen_bench.sv
module audio_wclk_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       ext_ws = 1'b0;
  logic [7:0] div_value, mode_value;
  logic [1:0] status;
  logic       bit_clk, word_strobe, sample_irq;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;

  audio_wclk_gen u_audio_wclk_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ext_ws(ext_ws), .div_value(div_value),
    .mode_value(mode_value), .status(status), .bit_clk(bit_clk),
    .word_strobe(word_strobe), .sample_irq(sample_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic pick(input int which);
    case (which)
      0:       return bit_clk;
      1:       return word_strobe;
      default: return status[1];
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d, output int stamp);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    stamp = cyc;
  endtask

  task automatic wait_change(input int which, output int stamp);
    logic v0;
    v0 = pick(which);
    stamp = -1;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (pick(which) != v0) begin
        stamp = cyc;
        break;
      end
    end
  endtask

  task automatic t_reset();
    chk(div_value == 8'd8, "R1 divider", div_value, 8);
    chk(mode_value == 8'd0, "R1 mode", mode_value, 0);
    chk(!bit_clk && !word_strobe && !sample_irq, "R1 outputs",
        {bit_clk, word_strobe, sample_irq}, 0);
    chk(status == 2'b10, "R1 status", status, 2);
  endtask

  task automatic t_regs();
    int s;
    wr(1'b1, 8'hFF, s);
    chk(mode_value == 8'h3D, "R2 mode mask", mode_value, 8'h3D);
    wr(1'b0, 8'h5A, s);
    chk(div_value == 8'h5A, "R2 divider load", div_value, 8'h5A);
    wr(1'b1, 8'h00, s);
  endtask

  task automatic t_master_period(input int d);
    int s, a, b, c;
    wr(1'b1, 8'h05, s);
    wr(1'b0, 8'(d), s);
    wait_change(0, a); wait_change(0, b); wait_change(0, c);
    chk(b - a == d + 1, "R3 bit clock half period", b - a, d + 1);
    chk(c - b == d + 1, "R3 bit clock half period", c - b, d + 1);
    wait_change(1, a); wait_change(1, b); wait_change(1, c);
    chk(b - a == 32 * (d + 1), "R4 strobe half frame", b - a, 32 * (d + 1));
    chk(c - b == 32 * (d + 1), "R4 strobe half frame", c - b, 32 * (d + 1));
    chk(status[0] == word_strobe, "R7 status level", status[0], word_strobe);
    chk(status[1] == !word_strobe, "R7 status left", status[1], !word_strobe);
  endtask

  task automatic t_restart();
    int s, w, a;
    wr(1'b1, 8'h05, s);
    wr(1'b0, 8'd5, s);
    repeat (300) @(negedge clk);
    wr(1'b0, 8'd2, w);
    chk(!bit_clk, "R5 bit clock cleared", bit_clk, 0);
    chk(!word_strobe, "R5 strobe cleared", word_strobe, 0);
    wait_change(0, a);
    chk(a - w == 3, "R5 first bit clock change", a - w, 3);
    wait_change(1, a);
    chk(a - w == 96, "R5 first strobe change", a - w, 96);
  endtask

  task automatic t_wsen_off();
    int s, bt, lt, hi;
    logic pb, pl;
    wr(1'b1, 8'h01, s);
    wr(1'b0, 8'd1, s);
    bt = 0; lt = 0; hi = 0;
    pb = bit_clk; pl = status[1];
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (word_strobe || status[0]) hi++;
      if (bit_clk != pb) bt++;
      if (status[1] != pl) lt++;
      pb = bit_clk; pl = status[1];
    end
    chk(hi == 0, "R6 strobe held low", hi, 0);
    chk(bt == 150, "R6 bit clock runs", bt, 150);
    chk(lt == 4, "R6 left flag follows phase", lt, 4);
  endtask

  task automatic t_irq(input logic [7:0] bits, input int exp_cnt, input int pol, input string req);
    int s, w, cnt;
    logic h1, h2, pirq, cur;
    wr(1'b1, 8'h04 | bits, s);
    wr(1'b0, 8'd0, s);
    repeat (3) @(negedge clk);
    wr(1'b1, 8'h05 | bits, w);
    cnt = 0; h1 = word_strobe; h2 = word_strobe; pirq = sample_irq;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      cur = word_strobe;
      if (sample_irq) begin
        cnt++;
        chk(h1 != h2, {req, " pulse one cycle after edge"}, h1, !h2);
        chk(!pirq, {req, " pulse width"}, pirq, 0);
        if (pol >= 0) chk(cur == pol[0], {req, " edge polarity"}, cur, pol);
      end
      h2 = h1; h1 = cur; pirq = sample_irq;
    end
    chk(cnt == exp_cnt, {req, " pulse count"}, cnt, exp_cnt);
  endtask

  task automatic t_slave();
    int s, cnt;
    wr(1'b1, 8'h18, s);
    repeat (5) @(negedge clk);
    chk(!bit_clk && !word_strobe, "R10 slave outputs low", {bit_clk, word_strobe}, 0);
    ext_ws = 1'b1;
    @(negedge clk);
    chk(status[0] == 1'b0, "R10 sync latency one edge", status[0], 0);
    @(negedge clk);
    chk(status[0] == 1'b1, "R10 status after two edges", status[0], 1);
    chk(status[1] == 1'b0, "R7 left flag in slave", status[1], 0);
    chk(!sample_irq, "R10 irq not yet", sample_irq, 0);
    @(negedge clk);
    chk(sample_irq, "R8 slave rising pulse", sample_irq, 1);
    @(negedge clk);
    chk(!sample_irq, "R8 slave pulse width", sample_irq, 0);
    ext_ws = 1'b0;
    repeat (3) @(negedge clk);
    chk(sample_irq, "R8 slave falling pulse", sample_irq, 1);
    chk(!bit_clk && !word_strobe, "R10 slave outputs stay low", {bit_clk, word_strobe}, 0);
    wr(1'b1, 8'h00, s);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i % 8 == 0) ext_ws = ~ext_ws;
      if (sample_irq) cnt++;
    end
    chk(cnt == 0, "R9 no select no pulse", cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_master_period(3);
    t_master_period(0);
    t_master_period(10);
    t_restart();
    t_wsen_off();
    t_irq(8'h08, 4, 1, "R8 rise only");
    t_irq(8'h10, 3, 0, "R8 fall only");
    t_irq(8'h18, 7, -1, "R8 both edges");
    t_irq(8'h20, 7, -1, "R9 every word");
    t_irq(8'h00, 0, -1, "R9 none selected");
    t_slave();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule